// File: doc/BRIEF.md
# Overlapped Fetch/Execute Slot Sequencer

This block is the hardwired timing core of a small two-stage processor. Opcodes are 32 bits wide, but the memory port is only 16 bits wide, so each opcode arrives as two halfword transfers. Each transfer takes two clocks: an address clock that carries the request, then a data clock that ends when the acknowledge arrives. One opcode therefore needs a window of four clocks.

The execute side runs in the same four clocks, on the opcode that the previous window fetched. The four slots of the window are: read source A, read source B, perform the operation and write the result, and evaluate the branch. A taken branch throws away the opcode that was prefetched in the same window. The target is then fetched in a window that has no execute activity, so any branch costs eight clocks.

The sequencer only produces strobes, fetch addresses and the current opcode. The ALU, the register file and any multi-word data access sit outside it. After reset the first window only fetches. A late acknowledge freezes the whole sequencer until the acknowledge arrives.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is asserted, `bus_req`, `instr_valid` and all four execute strobes are 0. The first request after reset addresses `RESET_ADDR` (default 0x0100).
- R2: A bus transfer is one clock with `bus_req`=1, followed by one or more data clocks that end on the first clock with `bus_ack`=1. `bus_req` is never 1 in a data clock.
- R3: The halfword at the window's fetch address A goes to opcode bits 15:0. The halfword at A+2 goes to bits 31:16. The result appears on `ir` when the opcode starts executing.
- R4: With no taken branch, the fetch address of each window is the previous one plus 4, wrapping modulo 2^AW.
- R5: In every executing window, `rd_src_a`, `rd_src_b`, `wr_result` and `br_eval` each pulse exactly once, in that order, on separate clocks. At most one of them is high in any clock.
- R6: With prompt acknowledges, consecutive non-branch opcodes start (`rd_src_a`) exactly four clocks apart.
- R7: The first window after reset fetches without any execute strobe. The first `rd_src_a` comes after exactly two completed transfers.
- R8: `br_taken`=1 during `br_eval` discards the prefetched opcode and restarts fetch at `br_target`. The next opcode starts eight clocks after the branch's `rd_src_a`.
- R9: `br_taken` has no effect in any clock without `br_eval`. This includes fetch-only windows and held clocks.
- R10: While a data clock waits for `bus_ack`, the sequencer holds its slot. No strobe and no new request is issued. Held clocks do not count toward the R6/R8 spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised inside |
| bus_req | output | 1 | Address clock of a halfword transfer |
| bus_addr | output | AW | Byte address of the halfword being fetched |
| bus_ack | input | 1 | Completes the data clock of a transfer |
| bus_rdata | input | 16 | Halfword returned with `bus_ack` |
| rd_src_a | output | 1 | Read strobe, first source register |
| rd_src_b | output | 1 | Read strobe, second source register |
| wr_result | output | 1 | Operate-and-write-back strobe |
| br_eval | output | 1 | Branch decision slot |
| br_taken | input | 1 | Branch outcome, used only with `br_eval` |
| br_target | input | AW | Fetch address after a taken branch |
| instr_valid | output | 1 | `ir` holds an opcode being executed |
| ir | output | 32 | Opcode being executed |

## Verification
The assertions assume the following about the inputs:
- `bus_ack` is meaningful only in a data clock.
- `br_taken` is already settled whenever `br_eval` is high.

The responder model never acknowledges in an address clock, and it drives `br_taken` half a clock ahead of the edge that uses it.

To probe R9, the stimulus deliberately holds `br_taken` high where it must be ignored: in fetch-only windows, in held clocks and in the source-A slot. It keeps `br_taken` low in the decision slot of non-branch opcodes.

Memory contents are the address XOR a key. This lets the scoreboard check both the halfword order and the fetch address from `ir` alone.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned OP_W   = 2 * HALF_W;

  // slot order is behaviour: odd slots are bus data clocks
  typedef enum logic [1:0] {
    SLOT_SRC_A  = 2'd0,
    SLOT_SRC_B  = 2'd1,
    SLOT_EXEC   = 2'd2,
    SLOT_BRANCH = 2'd3
  } slot_e;
endpackage

// File: rtl/seq_slot_ctr.sv
module seq_slot_ctr
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_ack,
  output logic  live,
  output slot_e slot,
  output logic  step,
  output logic  wend
);
  logic  live_q, live_d;
  slot_e slot_q, slot_d;

  // a data clock (odd slot) advances only with an acknowledge
  assign step = live_q && !(slot_q[0] && !bus_ack);
  assign wend = step && (slot_q == SLOT_BRANCH);
  assign live = live_q;
  assign slot = slot_q;

  always_comb begin
    live_d = 1'b1;
    slot_d = slot_q;
    if (step) slot_d = slot_e'(slot_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= SLOT_SRC_A;
    end else begin
      live_q <= live_d;
      slot_q <= slot_d;
    end
  end

  // R10: a waiting data clock freezes the slot
  p_hold_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && slot_q[0] && !bus_ack) |=> (slot_q == $past(slot_q)));
endmodule

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  slot_e             slot,
  input  logic              step,
  input  logic              wend,
  input  logic              redirect,
  input  logic [AW-1:0]     target,
  input  logic [HALF_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  output logic [OP_W-1:0]   opcode
);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);
  localparam logic [AW-1:0] OP_STEP   = AW'(4);

  logic [AW-1:0]     pc_q, pc_d;
  logic [HALF_W-1:0] lo_q, lo_d;
  logic              lo_en;

  assign bus_req  = live && !slot[0];
  assign bus_addr = slot[1] ? (pc_q + HALF_STEP) : pc_q;
  assign lo_en    = step && (slot == SLOT_SRC_B);
  assign opcode   = {bus_rdata, lo_q};

  always_comb begin
    pc_d = pc_q;
    if (wend) pc_d = redirect ? target : (pc_q + OP_STEP);
    lo_d = lo_en ? bus_rdata : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_ADDR;
      lo_q <= '0;
    end else begin
      pc_q <= pc_d;
      lo_q <= lo_d;
    end
  end

  // R4: sequential windows step by one opcode
  p_seq_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wend && !redirect) |=> (pc_q == $past(pc_q) + OP_STEP));
  // R2: a request never spans two clocks
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);
endmodule

// File: rtl/seq_exec.sv
module seq_exec
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  slot_e           slot,
  input  logic            step,
  input  logic            wend,
  input  logic [OP_W-1:0] opcode,
  input  logic            br_taken,
  output logic            redirect,
  output logic            instr_valid,
  output logic [OP_W-1:0] ir,
  output logic [3:0]      strobes
);
  logic            valid_q, valid_d;
  logic [OP_W-1:0] ir_q, ir_d;

  for (genvar s = 0; s < 4; s++) begin : g_strobe
    assign strobes[s] = valid_q && step && (slot == slot_e'(s));
  end

  assign redirect    = strobes[SLOT_BRANCH] && br_taken;
  assign instr_valid = valid_q;
  assign ir          = ir_q;

  always_comb begin
    valid_d = valid_q;
    ir_d    = ir_q;
    if (wend) begin
      valid_d = !redirect;
      if (!redirect) ir_d = opcode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ir_q    <= '0;
    end else begin
      valid_q <= valid_d;
      ir_q    <= ir_d;
    end
  end

  // R5: one slot strobe per clock at most
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
  // R8: a taken branch leaves the next window without an opcode
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes[SLOT_BRANCH] && br_taken) |=> !instr_valid);
  // R6: a normal window end always loads a new opcode
  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wend && !br_taken) |=> instr_valid);
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import seq_pkg::*;
#(
  parameter int unsigned AW           = 16,
  parameter logic [AW-1:0] RESET_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  input  logic              bus_ack,
  input  logic [HALF_W-1:0] bus_rdata,
  output logic              rd_src_a,
  output logic              rd_src_b,
  output logic              wr_result,
  output logic              br_eval,
  input  logic              br_taken,
  input  logic [AW-1:0]     br_target,
  output logic              instr_valid,
  output logic [OP_W-1:0]   ir
);
  logic [1:0]      rst_sync_q;
  logic            srst_n;
  logic            live, step, wend, redirect;
  slot_e           slot;
  logic [OP_W-1:0] opcode;
  logic [3:0]      strobes;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  seq_slot_ctr u_slot (
    .clk(clk), .rst_n(srst_n), .bus_ack(bus_ack),
    .live(live), .slot(slot), .step(step), .wend(wend)
  );

  seq_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst_n(srst_n), .live(live), .slot(slot), .step(step),
    .wend(wend), .redirect(redirect), .target(br_target),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
    .opcode(opcode)
  );

  seq_exec u_exec (
    .clk(clk), .rst_n(srst_n), .slot(slot), .step(step), .wend(wend),
    .opcode(opcode), .br_taken(br_taken), .redirect(redirect),
    .instr_valid(instr_valid), .ir(ir), .strobes(strobes)
  );

  assign rd_src_a  = strobes[SLOT_SRC_A];
  assign rd_src_b  = strobes[SLOT_SRC_B];
  assign wr_result = strobes[SLOT_EXEC];
  assign br_eval   = strobes[SLOT_BRANCH];
endmodule

// File: tb/fetch_exec_seq_test.sv
module fetch_exec_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY   = 16'hC3A5;
  localparam logic [15:0] START = 16'h0100;

  typedef struct packed {
    logic [31:0] op;
    logic [3:0]  gap;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req, bus_ack = 1'b0;
  logic [15:0] bus_addr, bus_rdata = '0;
  logic        rd_src_a, rd_src_b, wr_result, br_eval;
  logic        br_taken = 1'b0;
  logic [15:0] br_target = '0;
  logic        instr_valid;
  logic [31:0] ir;

  fetch_exec_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .rd_src_a(rd_src_a),
    .rd_src_b(rd_src_b), .wr_result(wr_result), .br_eval(br_eval),
    .br_taken(br_taken), .br_target(br_target), .instr_valid(instr_valid),
    .ir(ir)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_chk = 0, n_fail = 0;
  exp_t exp_q[$];
  bit   armed = 0, has_br = 0, use_dly = 0;
  logic [15:0] br_pc = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] op_at(input logic [15:0] pc);
    return {(pc + 16'd2) ^ KEY, pc ^ KEY};
  endfunction

  // responder: bus model plus br_taken drive
  bit          dphase, stall_now, first_req;
  int          wcnt, xfer, acks;
  logic [15:0] h_addr;
  always @(negedge clk) begin
    if (!rst_n) begin
      dphase = 0; stall_now = 0; first_req = 1; acks = 0; xfer = 0; wcnt = 0;
      bus_ack = 0; br_taken = 0;
    end else begin
      bus_ack = 0; stall_now = 0;
      if (dphase) begin
        check(!bus_req, "R2 req in data clock", 32'(bus_req), 32'd0);
        if (wcnt == 0) begin
          bus_ack = 1; bus_rdata = h_addr ^ KEY; dphase = 0; acks++;
        end else begin
          wcnt--; stall_now = 1;
        end
      end else if (bus_req) begin
        if (first_req) begin
          check(bus_addr == START, "R1 first fetch address", 32'(bus_addr), 32'(START));
          first_req = 0;
        end
        dphase = 1; h_addr = bus_addr; xfer++;
        wcnt = !use_dly ? 0 : ((xfer % 3 == 1) ? 2 : ((xfer % 5 == 0) ? 1 : 0));
      end
      // R9: br_taken held high wherever it must be ignored
      br_taken = (has_br && instr_valid && ((ir[15:0] ^ KEY) == br_pc))
                 || rd_src_a || !instr_valid || stall_now;
    end
  end

  // monitor: strobe order, opcode and spacing against the scoreboard
  int  gap, slot_exp;
  bit  first;
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst_n) begin
      gap = 0; slot_exp = 0; first = 1;
    end else begin
      logic [3:0] sv;
      exp_t e;
      if (!stall_now) gap++;
      sv = {br_eval, wr_result, rd_src_b, rd_src_a};
      if (stall_now) check(sv == 4'd0 && !bus_req, "R10 held clock quiet", 32'(sv), 32'd0);
      if (sv != 4'd0) begin
        check($countones(sv) == 1, "R5 single strobe", 32'(sv), 32'd1);
        check(sv == 4'(1 << slot_exp), "R5 strobe order", 32'(sv), 32'(1 << slot_exp));
        slot_exp = (slot_exp + 1) % 4;
      end
      if (rd_src_a && armed && exp_q.size() != 0) begin
        e = exp_q.pop_front();
        check(ir == e.op, "R3/R4/R8 opcode", ir, e.op);
        if (first) check(acks == 2, "R7 fetch-only first window", 32'(acks), 32'd2);
        if (e.gap != 0) check(gap == int'(e.gap), "R6/R8 start spacing", 32'(gap), 32'(e.gap));
        first = 0;
      end
      if (rd_src_a) gap = 0;
    end
  end

  // driver: reset, then push the expected opcode stream
  task automatic run_case(input bit br, input logic [15:0] bpc, input logic [15:0] tgt,
                          input bit dly, input int n);
    logic [15:0] pc = START;
    bit prev_br = 0;
    armed = 0;
    @(negedge clk); rst_n = 0;
    has_br = br; br_pc = bpc; br_target = tgt; use_dly = dly;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(!bus_req && !instr_valid && !rd_src_a && !rd_src_b && !wr_result && !br_eval,
          "R1 reset outputs", {26'd0, bus_req, instr_valid, rd_src_a, rd_src_b, wr_result, br_eval}, 32'd0);
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{op: op_at(pc), gap: (i == 0) ? 4'd0 : (prev_br ? 4'd8 : 4'd4)});
      prev_br = br && (pc == bpc);
      pc = prev_br ? tgt : pc + 16'd4;
    end
    armed = 1;
    @(negedge clk); rst_n = 1;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
    armed = 0;
  endtask

  initial begin
    run_case(0, 16'h0000, 16'h0000, 0, 6);   // straight line
    run_case(1, 16'h0108, 16'h0400, 0, 6);   // forward branch
    run_case(1, 16'h0104, 16'h0100, 1, 7);   // loop with late acks
    run_case(1, 16'h0100, 16'hFFF8, 0, 5);   // branch first, address wrap
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule